// File: doc/BRIEF.md
# Watchdog and Bus Timeout Supervisor

This block watches over a processor system with two counters that run independently. The first is a programmable watchdog that software must service. It counts down a loaded period in ticks of 1 µs or 1 ms. The tick is derived from the system clock using a programmed clock frequency in MHz. The second counter flags a bus cycle that has been stalled for too long. It counts the cycles in which the bus is busy and data-ready is absent.

Both events drive a single active-high terminal-count pulse. Each event also sets its own sticky status bit, which stays set until the status is read.

Software uses one write port with two registers. Register 0 is the control word and register 1 is the watchdog period. A service strobe, or a new period, restarts the watchdog.

Top module: `sup_timer`

## Requirements
- R1: After reset, `term_cnt`, `wd_flag` and `bto_flag` are 0. The control and period registers are 0, so neither counter can fire.
- R2: A write with `wr_sel`=0 loads the control word. Bits [5:0] hold the clock in MHz, bit 6 enables the bus timeout, bit 7 selects the long limit and bit 8 enables the watchdog. Bit 9 selects the 1 ms tick when 1 and the 1 µs tick when 0. A write with `wr_sel`=1 loads the 16-bit watchdog period.
- R3: With the short limit selected, `term_cnt` pulses after the 64th consecutive clock edge at which `bus_busy`=1 and `data_rdy`=0. It pulses at most once per bus cycle.
- R4: With the long limit selected, the same pulse comes after the 128th such edge; a cycle of 127 stalled edges gives none.
- R5: The bus counter clears whenever `bus_busy`=0 or `data_rdy`=1. It is held clear when the bus timeout is disabled.
- R6: With the 1 µs tick, a clock field of M and a period P, the watchdog expires M·P clock edges after it is enabled or reloaded. After each expiry it reloads P and repeats.
- R7: With the 1 ms tick, the watchdog expires 1000·M·P edges after it is enabled.
- R8: A `wd_kick` pulse, or a write of the period register, reloads the watchdog counter and its prescalers at that edge.
- R9: `term_cnt` is high for one clock per expiry event. A watchdog expiry and a bus timeout on the same edge give one pulse.
- R10: `wd_flag` and `bto_flag` are set by their own event and stay set until a clock edge with `stat_rd`=1 and no new event.
- R11: With the watchdog disabled or a clock field of 0, the watchdog never expires.
- R12: A period of 0 expires on the first tick, the same as a period of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = control word, 1 = watchdog period |
| wr_data | input | 16 | Write data |
| stat_rd | input | 1 | Status read strobe, clears the flags |
| bus_busy | input | 1 | Bus cycle in progress, active high |
| data_rdy | input | 1 | Data phase complete, active high |
| wd_kick | input | 1 | Watchdog service strobe |
| term_cnt | output | 1 | Terminal-count pulse, active high |
| wd_flag | output | 1 | Sticky: watchdog expired |
| bto_flag | output | 1 | Sticky: bus timeout occurred |

## Verification
Bus cycles of random length, with a random limit select, are run around both limits. These cycles separate an off-by-one timeout edge from a missing pulse or a repeated pulse. A cycle that is interrupted by data-ready, and a cycle with the timeout disabled, show whether the counter actually clears. Random clock fields and periods test the M·P expiry edge against the edge one cycle earlier. Directed kicks, period rewrites, the 1 ms tick, a zero clock field, a zero period and a case where both events land on the same edge separate reload, gating and merge faults.

// File: rtl/sup_timer_pkg.sv
package sup_timer_pkg;
   localparam int MHZ_W  = 6;
   localparam int CTRL_W = 10;

   typedef struct packed {
      logic             wd_ms;     // bit 9
      logic             wd_en;     // bit 8
      logic             bto_long;  // bit 7
      logic             bto_en;    // bit 6
      logic [MHZ_W-1:0] mhz;       // bits 5:0
   } ctrl_t;
endpackage

// File: rtl/st_tick_gen.sv
module st_tick_gen #(
   parameter int MHZ_W  = 6,
   parameter int MS_DIV = 1000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [MHZ_W-1:0] mhz,
   input  logic             ms_sel,
   output logic             tick
);
   localparam int MSC_W = $clog2(MS_DIV);

   logic [MHZ_W-1:0] pre_q;
   logic [MSC_W-1:0] msc_q;
   logic             us_tick;
   logic             ms_tick;

   assign us_tick = run && (mhz != '0) && (pre_q >= (mhz - MHZ_W'(1)));
   assign ms_tick = us_tick && (msc_q == MSC_W'(MS_DIV - 1));
   assign tick    = ms_sel ? ms_tick : us_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
         msc_q <= '0;
      end else if (!run || restart) begin
         pre_q <= '0;
         msc_q <= '0;
      end else begin
         pre_q <= us_tick ? '0 : pre_q + MHZ_W'(1);
         if (us_tick)
            msc_q <= ms_tick ? '0 : msc_q + MSC_W'(1);
      end
   end

   assert_ms_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      msc_q <= MSC_W'(MS_DIV - 1));
   assert_zero_clock_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mhz == '0) |-> !tick);
endmodule

// File: rtl/st_wdog.sv
module st_wdog #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          tick,
   input  logic          reload,
   input  logic [CW-1:0] load_val,
   output logic          expire
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         expire <= 1'b0;
      end else begin
         expire <= 1'b0;
         if (!en || reload) begin
            cnt_q <= load_val;
         end else if (tick) begin
            if (cnt_q <= CW'(1)) begin
               expire <= 1'b1;
               cnt_q  <= load_val;
            end else begin
               cnt_q <= cnt_q - CW'(1);
            end
         end
      end
   end

   assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !expire);
   assert_off_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !expire);
   assert_reload_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> !expire);
endmodule

// File: rtl/st_bus_guard.sv
module st_bus_guard #(
   parameter int LIM_SHORT = 64,
   parameter int LIM_LONG  = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic long_sel,
   input  logic busy,
   input  logic rdy,
   output logic timeout
);
   localparam int CW = $clog2(LIM_LONG + 1);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] limit;
   logic          stall;

   assign limit = long_sel ? CW'(LIM_LONG) : CW'(LIM_SHORT);
   assign stall = en && busy && !rdy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         timeout <= 1'b0;
      end else begin
         timeout <= stall && (cnt_q == limit - CW'(1));
         if (!stall)
            cnt_q <= '0;
         else if (cnt_q < limit)
            cnt_q <= cnt_q + CW'(1);
      end
   end

   assert_once_per_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |=> !timeout);
   assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(LIM_LONG));
   assert_idle_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy || rdy) |=> (cnt_q == '0));
endmodule

// File: rtl/sup_timer.sv
module sup_timer
   import sup_timer_pkg::*;
#(
   parameter int SETUP_W   = 16,
   parameter int LIM_SHORT = 64,
   parameter int LIM_LONG  = 128,
   parameter int MS_DIV    = 1000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               wr_sel,
   input  logic [SETUP_W-1:0] wr_data,
   input  logic               stat_rd,
   input  logic               bus_busy,
   input  logic               data_rdy,
   input  logic               wd_kick,
   output logic               term_cnt,
   output logic               wd_flag,
   output logic               bto_flag
);
   generate
      if (LIM_SHORT < 1 || LIM_SHORT >= LIM_LONG) begin : g_bad_lim
         $error("bus timeout limits must satisfy 0 < short < long");
      end
      if (SETUP_W < CTRL_W) begin : g_bad_w
         $error("write port too narrow for control word");
      end
      if (MS_DIV < 2) begin : g_bad_div
         $error("millisecond divider must exceed 1");
      end
   endgenerate

   ctrl_t              ctrl_q;
   logic [SETUP_W-1:0] setup_q;
   logic               setup_wr;
   logic               reload;
   logic [SETUP_W-1:0] load_val;
   logic               tick;
   logic               wd_exp;
   logic               bto_to;

   assign setup_wr = wr_en && wr_sel;
   assign reload   = wd_kick || setup_wr;
   assign load_val = setup_wr ? wr_data : setup_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         setup_q <= '0;
      end else if (wr_en) begin
         if (wr_sel) setup_q <= wr_data;
         else        ctrl_q  <= ctrl_t'(wr_data[CTRL_W-1:0]);
      end
   end

   st_tick_gen #(.MHZ_W(MHZ_W), .MS_DIV(MS_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(ctrl_q.wd_en), .restart(reload),
      .mhz(ctrl_q.mhz), .ms_sel(ctrl_q.wd_ms), .tick(tick));

   st_wdog #(.CW(SETUP_W)) u_wdog (
      .clk(clk), .rst_n(rst_n), .en(ctrl_q.wd_en), .tick(tick),
      .reload(reload), .load_val(load_val), .expire(wd_exp));

   st_bus_guard #(.LIM_SHORT(LIM_SHORT), .LIM_LONG(LIM_LONG)) u_bus (
      .clk(clk), .rst_n(rst_n), .en(ctrl_q.bto_en), .long_sel(ctrl_q.bto_long),
      .busy(bus_busy), .rdy(data_rdy), .timeout(bto_to));

   assign term_cnt = wd_exp || bto_to;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wd_flag  <= 1'b0;
         bto_flag <= 1'b0;
      end else begin
         if (wd_exp)       wd_flag <= 1'b1;
         else if (stat_rd) wd_flag <= 1'b0;
         if (bto_to)       bto_flag <= 1'b1;
         else if (stat_rd) bto_flag <= 1'b0;
      end
   end

   assert_wd_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_flag && !stat_rd) |=> wd_flag);
   assert_bto_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bto_flag && !stat_rd) |=> bto_flag);
   assert_wd_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wd_exp |=> wd_flag);
   assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !term_cnt) |=> (!wd_flag && !bto_flag));
endmodule

// File: tb/sim_sup_timer.sv
module sim_sup_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_sel = 1'b0;
   logic [15:0] wr_data = '0;
   logic        stat_rd = 1'b0;
   logic        bus_busy = 1'b0;
   logic        data_rdy = 1'b0;
   logic        wd_kick = 1'b0;
   logic        term_cnt, wd_flag, bto_flag;
   int n_chk = 0;
   int n_err = 0;

   always #4 clk = ~clk;

   sup_timer u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .stat_rd(stat_rd), .bus_busy(bus_busy),
      .data_rdy(data_rdy), .wd_kick(wd_kick), .term_cnt(term_cnt),
      .wd_flag(wd_flag), .bto_flag(bto_flag));

   function automatic int bto_limit(input bit long_sel);
      return long_sel ? 128 : 64;
   endfunction

   function automatic int wd_period(input int m, input int p, input bit ms);
      int pp = (p == 0) ? 1 : p;
      return (ms ? 1000 : 1) * m * pp;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic wr(input bit sel, input int data);
      wr_en = 1'b1; wr_sel = sel; wr_data = 16'(data);
      step();
      wr_en = 1'b0;
   endtask

   task automatic clear_flags();
      stat_rd = 1'b1; step(); stat_rd = 1'b0;
   endtask

   // bus cycle of len stalled edges; expects a single pulse at edge lim if len >= lim
   task automatic bus_cycle(input int len, input int lim, input string tag);
      int pos = -1;
      int cnt = 0;
      bus_busy = 1'b1;
      for (int i = 1; i <= len; i++) begin
         step();
         if (term_cnt) begin cnt++; if (pos < 0) pos = i; end
      end
      bus_busy = 1'b0;
      for (int i = 0; i < 2; i++) begin
         step();
         if (term_cnt) cnt++;
      end
      chk(pos == ((len >= lim) ? lim : -1), tag, pos, (len >= lim) ? lim : -1);
      chk(cnt == ((len >= lim) ? 1 : 0), tag, cnt, (len >= lim) ? 1 : 0);
   endtask

   // watchdog expected to expire exactly n edges from now
   task automatic wd_run(input int n, input string tag);
      int early = 0;
      for (int i = 1; i < n; i++) begin
         step();
         if (term_cnt) early++;
      end
      chk(early == 0, tag, early, 0);
      step();
      chk(term_cnt == 1'b1, tag, term_cnt, 1);
      step();
      chk(term_cnt == 1'b0, tag, term_cnt, 0);
   endtask

   task automatic quiet(input int n, input string tag);
      int seen = 0;
      for (int i = 0; i < n; i++) begin
         step();
         if (term_cnt) seen++;
      end
      chk(seen == 0, tag, seen, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      int seed;
      seed = $urandom(32'h5A17);
      repeat (3) step();
      rst_n = 1'b1;
      step();
      // R1: reset state
      chk(term_cnt == 0, "R1 term", term_cnt, 0);
      chk(wd_flag == 0 && bto_flag == 0, "R1 flags", {wd_flag, bto_flag}, 0);
      quiet(200, "R1 idle");

      // R2 / R3: short limit via control bit 6
      wr(0, 16'h040);
      bus_cycle(70, 64, "R3 short");
      chk(bto_flag == 1, "R10 bto set", bto_flag, 1);
      chk(wd_flag == 0, "R10 wd clear", wd_flag, 0);
      quiet(5, "R10 no repeat");
      chk(bto_flag == 1, "R10 sticky", bto_flag, 1);
      clear_flags();
      chk(bto_flag == 0, "R10 read clears", bto_flag, 0);
      bus_cycle(64, 64, "R3 exact");
      bus_cycle(63, 64, "R3 under");

      // R4: long limit, bit 7
      wr(0, 16'h0C0);
      bus_cycle(127, 128, "R4 under");
      bus_cycle(130, 128, "R4 over");

      // R5: data ready clears counter mid-cycle
      wr(0, 16'h040);
      bus_busy = 1'b1;
      repeat (60) step();
      data_rdy = 1'b1; step(); data_rdy = 1'b0;
      quiet(60, "R5 rdy clears");
      bus_busy = 1'b0; step();
      wr(0, 16'h080);
      bus_cycle(200, 100000, "R5 disabled");

      // R3/R4 random bus cycles
      for (int it = 0; it < 16; it++) begin
         bit sel = 1'($urandom % 2);
         int len = 1 + int'($urandom % 160);
         wr(0, sel ? 16'h0C0 : 16'h040);
         bus_cycle(len, bto_limit(sel), sel ? "R4 random" : "R3 random");
      end
      wr(0, 0);

      // R6: 1 us tick, M=3, P=5
      wr(1, 5);
      wr(0, 16'h103);
      wd_run(wd_period(3, 5, 0), "R6 first");
      wd_run(wd_period(3, 5, 0) - 1, "R6 repeat");
      chk(wd_flag == 1, "R10 wd set", wd_flag, 1);
      // R8: kick reloads
      quiet(8, "R8 pre kick");
      wd_kick = 1'b1; step(); wd_kick = 1'b0;
      wd_run(15, "R8 kick");
      wr(1, 2);
      wd_run(6, "R8 setup write");

      // R6 random periods
      for (int it = 0; it < 6; it++) begin
         int m = 1 + int'($urandom % 6);
         int p = 1 + int'($urandom % 12);
         wr(0, 0);
         wr(1, p);
         wr(0, 16'h100 | m);
         wd_run(wd_period(m, p, 0), "R6 random");
      end

      // R7: 1 ms tick, M=1, P=2
      wr(0, 0);
      wr(1, 2);
      wr(0, 16'h301);
      wd_run(wd_period(1, 2, 1), "R7 ms");

      // R11: zero clock field, then disabled watchdog
      wr(0, 0);
      wr(1, 1);
      wr(0, 16'h100);
      quiet(3000, "R11 zero clock");
      wr(0, 16'h003);
      quiet(100, "R11 disabled");

      // R12: period 0 acts as 1
      wr(1, 0);
      wr(0, 16'h102);
      wd_run(2, "R12 zero period");

      // R9: both events on the same edge
      wr(0, 0);
      wr(1, 64);
      clear_flags();
      wr(0, 16'h141);
      bus_busy = 1'b1;
      quiet(63, "R9 before");
      step();
      chk(term_cnt == 1, "R9 merged pulse", term_cnt, 1);
      step();
      chk(term_cnt == 0, "R9 one clock", term_cnt, 0);
      chk(wd_flag == 1 && bto_flag == 1, "R10 both set", {wd_flag, bto_flag}, 3);
      bus_busy = 1'b0;
      wr(0, 0);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule